// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block runs whole I2C transactions without software in the loop. It drives a byte-level bus engine through a narrow command port, one phase at a time: START, address byte, register-address bytes, data bytes, repeated START and STOP. Each command the block issues carries an 8-bit control word. When the engine raises its completion flag, the block compares the engine's 8-bit status code with the code that phase should produce. Bus timing belongs to the engine and is not modelled here.

Three operations are offered. A write sends the chip address with the write bit, the register-address bytes and the payload bytes. A combined read sends the chip address with the write bit and the register-address bytes, then a repeated START, the chip address with the read bit, and finally receives the payload. A probe addresses the chip for reading, receives one byte, refuses it and closes the bus. The block finishes every transaction with a one-cycle `done` pulse and a 32-bit result word. The word is zero on success. On failure it holds the context of the first phase that went wrong.

Top module: `i2c_txn_seq`

## Requirements
- R1: A request is taken only while `busy` is low. When a transaction ends, `done` is high for exactly one cycle, and in that same cycle `busy` is low. A transaction in which every phase returns its expected code and STOP completes gives `result` = 0. `result` holds its value until the next `done`.
- R2: A failing `result` is packed as {class[31:24], control[23:16], status[15:8], expected[7:0]}. Control word bits are enable 0x40, START 0x20, STOP 0x10 and ACK 0x04. In the reported control byte, bit 0x08 is set only when the engine had signalled completion for that phase.
- R3: Class 1 means the engine completed with a status code other than the expected one; the status byte is the returned code. Class 2 means that no completion came within TIMEOUT_CYC cycles of the command; the status byte is the engine status bus at that moment.
- R4: A write (`req_op` = 0) issues START, expecting 0x08. It then sends {chip, 0}, expecting 0x18, then each register-address byte and each payload byte, each expecting 0x28, then STOP. Payload bytes are taken from `wr_data`, and each one is consumed with a `wr_pop` pulse.
- R5: A read (`req_op` = 1) sends the register-address phase like a write. With no STOP in between, it then issues a START expecting 0x10, then sends {chip, 1} expecting 0x40.
- R6: In a read, every received byte except the last carries ACK and expects 0x50. The last byte carries no ACK and expects 0x58. Each accepted byte appears on `rd_data` with a one-cycle `rd_valid`.
- R7: Register-address bytes come from `req_reg_addr`, least significant byte first. Their count is `req_alen` from 0 to 4, and any larger value is treated as 4.
- R8: STOP (control 0x50) is issued after every transaction, including one that failed. It completes when the engine status reads 0xF8. A STOP timeout reports {2, 0x50, status, 0xF8}, but only when no earlier phase had failed; otherwise the first failure is kept.
- R9: A probe (`req_op` = 2) sends {chip, 1} expecting 0x40, receives one byte without ACK expecting 0x58, then STOPs.
- R10: `busy` is high from the accept cycle until the `done` cycle. A request made while busy is ignored and does not disturb the running transaction.
- R11: A write with a payload length of 0 still sends its register-address bytes and then STOPs.
- R12: After the first failing phase, the only further command issued is STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 write, 1 read, 2 probe |
| req_chip | input | 7 | 7-bit chip address |
| req_reg_addr | input | 8*ABYTES | Register address, low byte sent first |
| req_alen | input | $clog2(ABYTES+1) | Number of register-address bytes |
| req_dlen | input | DLEN_W | Payload length in bytes |
| busy | output | 1 | Transaction in progress |
| wr_data | input | 8 | Next payload byte for a write |
| wr_pop | output | 1 | Current `wr_data` byte consumed |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` valid for one cycle |
| eng_cmd_valid | output | 1 | Command strobe to the engine |
| eng_ctrl | output | 8 | Control word of the current command |
| eng_byte | output | 8 | Byte to send |
| eng_done | input | 1 | Engine completion flag pulse |
| eng_status | input | 8 | Engine status code |
| eng_rdata | input | 8 | Byte received by the engine |
| done | output | 1 | Transaction finished |
| result | output | 32 | 0 or packed failure context |

## Verification
The bench targets the address NAK during a probe, which must report {1, 0x48, 0x48, 0x40}. It also covers a register-address count above four, which must be clamped and never wrap, and a zero-length write, which a sequencer with a poorly placed length test would send stray payload bytes for or skip STOP. Engine hangs are injected at chosen phases to show that the status byte is captured at timeout and that nothing but STOP follows. A STOP that never reaches the idle code is combined with an earlier failure to show the first failure wins. A stray request during a busy transaction shows that a design accepting it would corrupt the sent byte log or produce two `done` pulses.

// File: rtl/i2c_seq_pkg.sv
// Package: shared codes and types for the I2C transaction sequencer.
// Assumes an engine whose status codes follow the standard master codes.
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_PROBE = 2'd2
    } op_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_START,
        PH_ADDR1,
        PH_REGA,
        PH_WDATA,
        PH_RSTART,
        PH_ADDR2,
        PH_RDATA,
        PH_STOP
    } phase_e;

    localparam logic [7:0] CTL_ACK  = 8'h04;
    localparam logic [7:0] CTL_FLAG = 8'h08;
    localparam logic [7:0] CTL_STO  = 8'h10;
    localparam logic [7:0] CTL_STA  = 8'h20;
    localparam logic [7:0] CTL_EN   = 8'h40;

    localparam logic [7:0] ST_START  = 8'h08;
    localparam logic [7:0] ST_RSTART = 8'h10;
    localparam logic [7:0] ST_AW_ACK = 8'h18;
    localparam logic [7:0] ST_DW_ACK = 8'h28;
    localparam logic [7:0] ST_AR_ACK = 8'h40;
    localparam logic [7:0] ST_RD_ACK = 8'h50;
    localparam logic [7:0] ST_RD_NAK = 8'h58;
    localparam logic [7:0] ST_IDLE   = 8'hF8;

    localparam logic [7:0] ERR_STATUS  = 8'h01;
    localparam logic [7:0] ERR_TIMEOUT = 8'h02;

    function automatic logic [31:0] pack_err(input logic [7:0] cls, input logic [7:0] ctl,
                                             input logic [7:0] st, input logic [7:0] ex);
        return {cls, ctl, st, ex};
    endfunction

endpackage

// File: rtl/i2c_seq_regsel.sv
// Register-address byte selector: picks byte idx of a packed word, byte 0 lowest.
// Assumes NB >= 2; an index past NB yields zero.
module i2c_seq_regsel #(
    parameter int NB = 4,
    parameter int IW = $clog2(NB)
) (
    input  logic [8*NB-1:0] word,
    input  logic [IW-1:0]   idx,
    output logic [7:0]      sel_byte
);
    logic [7:0] lanes [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    // Selects the addressed lane, guarding an out-of-range index.
    always_comb begin
        sel_byte = 8'h00;
        if (int'(idx) < NB) sel_byte = lanes[idx];
    end
endmodule

// File: rtl/i2c_seq_timer.sv
// Phase watchdog: counts wait cycles after a command and flags expiry at LIMIT.
// Assumes clear is pulsed on the issue cycle and run is high while waiting.
module i2c_seq_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Counts waiting cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (clear)              cnt <= '0;
        else if (run && cnt != LIM)  cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LIM);

    a_r3_expiry_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> $past(run));
    a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expired);
endmodule

// File: rtl/i2c_seq_errcap.sv
// First-failure capture: keeps the first recorded error word until cleared.
// Assumes clear comes at accept and record only while a transaction runs.
module i2c_seq_errcap (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        record,
    input  logic [31:0] rec_word,
    output logic        has_err,
    output logic [31:0] err_word
);
    // Latches only the first error of a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            has_err  <= 1'b0;
            err_word <= '0;
        end else if (clear) begin
            has_err  <= 1'b0;
            err_word <= '0;
        end else if (record && !has_err) begin
            has_err  <= 1'b1;
            err_word <= rec_word;
        end
    end

    a_r8_first_err_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (has_err && !clear) |=> (has_err && $stable(err_word)));
endmodule

// File: rtl/i2c_txn_seq.sv
// I2C transaction sequencer: issues START/address/data/STOP commands to a
// byte engine, checks each completion status and packs the first failure.
// Assumes the engine pulses eng_done once per non-STOP command and shows
// the idle code on eng_status once a STOP has finished.
module i2c_txn_seq
    import i2c_seq_pkg::*;
#(
    parameter int ABYTES      = 4,
    parameter int DLEN_W      = 8,
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [1:0]                   req_op,
    input  logic [6:0]                   req_chip,
    input  logic [8*ABYTES-1:0]          req_reg_addr,
    input  logic [$clog2(ABYTES+1)-1:0]  req_alen,
    input  logic [DLEN_W-1:0]            req_dlen,
    output logic                         busy,
    input  logic [7:0]                   wr_data,
    output logic                         wr_pop,
    output logic [7:0]                   rd_data,
    output logic                         rd_valid,
    output logic                         eng_cmd_valid,
    output logic [7:0]                   eng_ctrl,
    output logic [7:0]                   eng_byte,
    input  logic                         eng_done,
    input  logic [7:0]                   eng_status,
    input  logic [7:0]                   eng_rdata,
    output logic                         done,
    output logic [31:0]                  result
);
    localparam int IW   = $clog2(ABYTES);
    localparam int AL_W = $clog2(ABYTES + 1);
    localparam logic [AL_W-1:0] AL_MAX = AL_W'(ABYTES);

    phase_e              ph;
    logic                waiting;
    op_e                 op_q;
    logic [6:0]          chip_q;
    logic [8*ABYTES-1:0] raddr_q;
    logic [AL_W-1:0]     alen_q;
    logic [DLEN_W-1:0]   cnt_q;
    logic [IW-1:0]       idx_q;
    logic [7:0]          exp_q;

    logic        issue, accept, last_rx, tmo;
    logic        step_ok, step_bad, step_to, stop_ok, stop_to;
    logic        has_err;
    logic [31:0] err_word, rec_word;
    logic [7:0]  ctrl_n, byte_n, exp_n, reg_byte;
    phase_e      after_reg;
    op_e         op_in;
    logic [AL_W-1:0] alen_in;

    assign accept  = (ph == PH_IDLE) && req_valid;
    assign issue   = (ph != PH_IDLE) && !waiting;
    assign last_rx = (cnt_q == DLEN_W'(1));
    assign wr_pop  = issue && (ph == PH_WDATA);

    // Decodes the request opcode; unused code 3 runs as a write.
    always_comb begin
        case (req_op)
            2'd1:    op_in = OP_READ;
            2'd2:    op_in = OP_PROBE;
            default: op_in = OP_WRITE;
        endcase
        alen_in = (req_alen > AL_MAX) ? AL_MAX : req_alen;
    end

    // Chooses the phase that follows the register-address bytes.
    always_comb begin
        if (op_q == OP_WRITE) after_reg = (cnt_q != '0) ? PH_WDATA : PH_STOP;
        else                  after_reg = PH_RSTART;
    end

    i2c_seq_regsel #(.NB(ABYTES), .IW(IW)) u_regsel (
        .word     (raddr_q),
        .idx      (idx_q),
        .sel_byte (reg_byte)
    );

    // Forms the control word, byte and expected status of the current phase.
    always_comb begin
        ctrl_n = CTL_EN;
        byte_n = 8'h00;
        exp_n  = ST_IDLE;
        case (ph)
            PH_START:  begin ctrl_n = CTL_EN | CTL_STA; exp_n = ST_START; end
            PH_ADDR1:  begin
                byte_n = {chip_q, (op_q == OP_PROBE)};
                exp_n  = (op_q == OP_PROBE) ? ST_AR_ACK : ST_AW_ACK;
            end
            PH_REGA:   begin byte_n = reg_byte; exp_n = ST_DW_ACK; end
            PH_WDATA:  begin byte_n = wr_data;  exp_n = ST_DW_ACK; end
            PH_RSTART: begin ctrl_n = CTL_EN | CTL_STA; exp_n = ST_RSTART; end
            PH_ADDR2:  begin byte_n = {chip_q, 1'b1}; exp_n = ST_AR_ACK; end
            PH_RDATA:  begin
                ctrl_n = last_rx ? CTL_EN : (CTL_EN | CTL_ACK);
                exp_n  = last_rx ? ST_RD_NAK : ST_RD_ACK;
            end
            PH_STOP:   begin ctrl_n = CTL_EN | CTL_STO; exp_n = ST_IDLE; end
            default:   ;
        endcase
    end

    i2c_seq_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (issue),
        .run     (waiting),
        .expired (tmo)
    );

    // Classifies the outcome of the phase being waited on.
    always_comb begin
        step_ok  = waiting && (ph != PH_STOP) && eng_done && (eng_status == exp_q);
        step_bad = waiting && (ph != PH_STOP) && eng_done && (eng_status != exp_q);
        step_to  = waiting && (ph != PH_STOP) && !eng_done && tmo;
        stop_ok  = waiting && (ph == PH_STOP) && (eng_status == ST_IDLE);
        stop_to  = waiting && (ph == PH_STOP) && (eng_status != ST_IDLE) && tmo;
        rec_word = step_bad ? pack_err(ERR_STATUS, eng_ctrl | CTL_FLAG, eng_status, exp_q)
                            : pack_err(ERR_TIMEOUT, eng_ctrl, eng_status, exp_q);
    end

    i2c_seq_errcap u_errcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .record   (step_bad || step_to),
        .rec_word (rec_word),
        .has_err  (has_err),
        .err_word (err_word)
    );

    // Main sequencer: accept, issue, wait, advance or divert to STOP, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph            <= PH_IDLE;
            waiting       <= 1'b0;
            busy          <= 1'b0;
            op_q          <= OP_WRITE;
            chip_q        <= '0;
            raddr_q       <= '0;
            alen_q        <= '0;
            cnt_q         <= '0;
            idx_q         <= '0;
            exp_q         <= '0;
            eng_cmd_valid <= 1'b0;
            eng_ctrl      <= '0;
            eng_byte      <= '0;
            done          <= 1'b0;
            result        <= '0;
            rd_valid      <= 1'b0;
            rd_data       <= '0;
        end else begin
            eng_cmd_valid <= 1'b0;
            done          <= 1'b0;
            rd_valid      <= 1'b0;
            if (ph == PH_IDLE) begin
                if (req_valid) begin
                    busy    <= 1'b1;
                    ph      <= PH_START;
                    waiting <= 1'b0;
                    op_q    <= op_in;
                    chip_q  <= req_chip;
                    raddr_q <= req_reg_addr;
                    alen_q  <= alen_in;
                    cnt_q   <= (op_in == OP_PROBE) ? DLEN_W'(1) : req_dlen;
                    idx_q   <= '0;
                end
            end else if (issue) begin
                eng_cmd_valid <= 1'b1;
                eng_ctrl      <= ctrl_n;
                eng_byte      <= byte_n;
                exp_q         <= exp_n;
                waiting       <= 1'b1;
            end else if (ph == PH_STOP) begin
                if (stop_ok || stop_to) begin
                    done    <= 1'b1;
                    busy    <= 1'b0;
                    ph      <= PH_IDLE;
                    waiting <= 1'b0;
                    if (has_err)      result <= err_word;
                    else if (stop_to) result <= pack_err(ERR_TIMEOUT, eng_ctrl, eng_status, ST_IDLE);
                    else              result <= '0;
                end
            end else if (step_bad || step_to) begin
                ph      <= PH_STOP;
                waiting <= 1'b0;
            end else if (step_ok) begin
                waiting <= 1'b0;
                case (ph)
                    PH_START:  ph <= PH_ADDR1;
                    PH_ADDR1: begin
                        if (op_q == OP_PROBE)    ph <= PH_RDATA;
                        else if (alen_q != '0)   ph <= PH_REGA;
                        else                     ph <= after_reg;
                    end
                    PH_REGA: begin
                        idx_q <= idx_q + 1'b1;
                        if (AL_W'(idx_q) + AL_W'(1) == alen_q) ph <= after_reg;
                    end
                    PH_WDATA: begin
                        cnt_q <= cnt_q - 1'b1;
                        if (last_rx) ph <= PH_STOP;
                    end
                    PH_RSTART: ph <= PH_ADDR2;
                    PH_ADDR2:  ph <= (cnt_q != '0) ? PH_RDATA : PH_STOP;
                    PH_RDATA: begin
                        rd_valid <= 1'b1;
                        rd_data  <= eng_rdata;
                        cnt_q    <= cnt_q - 1'b1;
                        if (last_rx) ph <= PH_STOP;
                    end
                    default: ph <= PH_STOP;
                endcase
            end
        end
    end

    a_r10_cmd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_valid |-> busy);
    a_r1_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r10_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((eng_ctrl & CTL_STO) != 8'h00));
    a_r12_one_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_valid |=> !eng_cmd_valid);
    a_r6_rx_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);
endmodule

// File: tb/i2c_txn_seq_tb.sv
module i2c_txn_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [6:0]  req_chip = '0;
    logic [31:0] req_reg_addr = '0;
    logic [2:0]  req_alen = '0;
    logic [7:0]  req_dlen = '0;
    logic        busy, wr_pop, rd_valid, eng_cmd_valid, done;
    logic [7:0]  wr_data, rd_data, eng_ctrl, eng_byte;
    logic        eng_done;
    logic [7:0]  eng_status, eng_rdata;
    logic [31:0] result;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_txn_seq #(.ABYTES(4), .DLEN_W(8), .TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_chip(req_chip), .req_reg_addr(req_reg_addr), .req_alen(req_alen),
        .req_dlen(req_dlen), .busy(busy), .wr_data(wr_data), .wr_pop(wr_pop),
        .rd_data(rd_data), .rd_valid(rd_valid), .eng_cmd_valid(eng_cmd_valid),
        .eng_ctrl(eng_ctrl), .eng_byte(eng_byte), .eng_done(eng_done),
        .eng_status(eng_status), .eng_rdata(eng_rdata), .done(done), .result(result)
    );

    // bench control
    logic       tb_clr = 1'b0;
    int         hang_at = 99;
    logic       stop_hang = 1'b0;
    logic [6:0] pres_chip = '0;
    logic [7:0] wbuf [32];
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;

    // engine model state
    int         widx, cmd_idx, nsent, nstop, rcv_idx, nrcv, ndone, dly, stop_cnt;
    logic       in_txn, addr_next, rd_mode, slave_ok, pend;
    logic [7:0] pend_st, m_st;
    logic [7:0] sent [32];
    logic [7:0] rbuf [32];

    assign wr_data = wbuf[widx[4:0]];

    // Engine model: status codes follow bus state, optional hang and slow STOP.
    always @(posedge clk) begin
        if (!rst_n) begin
            eng_done <= 1'b0; eng_status <= 8'hF8; eng_rdata <= 8'h00;
            widx <= 0; cmd_idx <= 0; nsent <= 0; nstop <= 0; rcv_idx <= 0;
            in_txn <= 1'b0; addr_next <= 1'b0; rd_mode <= 1'b0; slave_ok <= 1'b0;
            pend <= 1'b0; pend_st <= 8'h00; dly <= 0; stop_cnt <= 0;
        end else if (tb_clr) begin
            eng_done <= 1'b0; widx <= 0; cmd_idx <= 0; nsent <= 0; nstop <= 0;
            rcv_idx <= 0; pend <= 1'b0;
        end else begin
            eng_done <= 1'b0;
            if (wr_pop) widx <= widx + 1;
            if (eng_cmd_valid) begin
                if ((eng_ctrl & 8'h10) != 0) begin
                    nstop <= nstop + 1; in_txn <= 1'b0; rd_mode <= 1'b0;
                    stop_cnt <= stop_hang ? TMO + 20 : 3;
                end else begin
                    cmd_idx <= cmd_idx + 1;
                    if ((eng_ctrl & 8'h20) != 0) begin
                        m_st = in_txn ? 8'h10 : 8'h08;
                        in_txn <= 1'b1; addr_next <= 1'b1; rd_mode <= 1'b0;
                    end else if (addr_next) begin
                        addr_next <= 1'b0;
                        rd_mode <= eng_byte[0];
                        slave_ok <= (eng_byte[7:1] == pres_chip);
                        if (eng_byte[7:1] == pres_chip) m_st = eng_byte[0] ? 8'h40 : 8'h18;
                        else                            m_st = eng_byte[0] ? 8'h48 : 8'h20;
                        sent[nsent[4:0]] <= eng_byte; nsent <= nsent + 1;
                    end else if (rd_mode) begin
                        m_st = ((eng_ctrl & 8'h04) != 0) ? 8'h50 : 8'h58;
                        eng_rdata <= 8'hA0 + 8'(rcv_idx); rcv_idx <= rcv_idx + 1;
                    end else begin
                        m_st = slave_ok ? 8'h28 : 8'h30;
                        sent[nsent[4:0]] <= eng_byte; nsent <= nsent + 1;
                    end
                    if (cmd_idx != hang_at) begin
                        pend <= 1'b1; pend_st <= m_st; dly <= $urandom_range(0, 3);
                    end
                end
            end
            if (pend) begin
                if (dly == 0) begin eng_done <= 1'b1; eng_status <= pend_st; pend <= 1'b0; end
                else dly <= dly - 1;
            end
            if (stop_cnt != 0) begin
                stop_cnt <= stop_cnt - 1;
                if (stop_cnt == 1) eng_status <= 8'hF8;
            end
        end
    end

    // Output collector for received bytes and done pulses.
    always @(posedge clk) begin
        if (!rst_n || tb_clr) begin nrcv <= 0; ndone <= 0; end
        else begin
            if (rd_valid) begin rbuf[nrcv[4:0]] <= rd_data; nrcv <= nrcv + 1; end
            if (done) ndone <= ndone + 1;
        end
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference plan
    logic [7:0] p_ctrl [32];
    logic [7:0] p_exp  [32];
    logic [7:0] p_act  [32];
    int np;
    logic [7:0] x_sent [32];
    int nx;

    function automatic logic [31:0] pk(input logic [7:0] c, input logic [7:0] k,
                                       input logic [7:0] s, input logic [7:0] e);
        return {c, k, s, e};
    endfunction

    task automatic add(input logic [7:0] c, input logic [7:0] e, input logic [7:0] a);
        p_ctrl[np] = c; p_exp[np] = e; p_act[np] = a; np = np + 1;
    endtask

    task automatic build(input int op, input logic [6:0] chip, input logic [31:0] ra,
                         input int alen, input int dlen, input logic pres);
        int ae;
        ae = (alen > 4) ? 4 : alen;
        np = 0; nx = 0;
        add(8'h60, 8'h08, 8'h08);
        if (op == 2) begin
            add(8'h40, 8'h40, pres ? 8'h40 : 8'h48); x_sent[nx] = {chip, 1'b1}; nx++;
            add(8'h40, 8'h58, 8'h58);
            return;
        end
        add(8'h40, 8'h18, pres ? 8'h18 : 8'h20); x_sent[nx] = {chip, 1'b0}; nx++;
        for (int i = 0; i < ae; i++) begin
            add(8'h40, 8'h28, pres ? 8'h28 : 8'h30); x_sent[nx] = ra[8*i +: 8]; nx++;
        end
        if (op == 0) begin
            for (int i = 0; i < dlen; i++) begin
                add(8'h40, 8'h28, pres ? 8'h28 : 8'h30); x_sent[nx] = wbuf[i]; nx++;
            end
        end else begin
            add(8'h60, 8'h10, 8'h10);
            add(8'h40, 8'h40, pres ? 8'h40 : 8'h48); x_sent[nx] = {chip, 1'b1}; nx++;
            for (int i = 0; i < dlen; i++) begin
                if (i == dlen - 1) add(8'h40, 8'h58, 8'h58);
                else               add(8'h44, 8'h50, 8'h50);
            end
        end
    endtask

    task automatic ref_run(output logic [31:0] res, output int ncmd, output logic ok);
        logic [7:0] prev;
        prev = 8'hF8; ok = 1'b1; res = 32'h0; ncmd = np;
        for (int i = 0; i < np; i++) begin
            if (i == hang_at) begin
                res = pk(8'h02, p_ctrl[i], prev, p_exp[i]); ncmd = i + 1; ok = 1'b0; break;
            end
            if (p_act[i] != p_exp[i]) begin
                res = pk(8'h01, p_ctrl[i] | 8'h08, p_act[i], p_exp[i]); ncmd = i + 1; ok = 1'b0; break;
            end
            prev = p_act[i];
        end
        if (ok && stop_hang) res = pk(8'h02, 8'h50, prev, 8'hF8);
    endtask

    task automatic run_txn(input int op, input logic [6:0] chip, input logic [31:0] ra,
                           input int alen, input int dlen, input logic pres,
                           input int hang, input logic shang, input logic inject, input string tag);
        logic [31:0] xres;
        int xcmd, waitc;
        logic ok;
        for (int i = 0; i < 32; i++) wbuf[i] = 8'($urandom);
        @(negedge clk);
        hang_at = hang; stop_hang = shang; pres_chip = pres ? chip : (chip ^ 7'h01);
        tb_clr = 1'b1;
        @(negedge clk);
        tb_clr = 1'b0;
        req_op = 2'(op); req_chip = chip; req_reg_addr = ra;
        req_alen = 3'(alen); req_dlen = 8'(dlen); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, {tag, " R10 busy after accept"}, 32'(busy), 32'd1);
        if (inject) begin
            repeat (3) @(negedge clk);
            req_op = 2'd1; req_chip = ~chip; req_dlen = 8'd5; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        waitc = 0;
        while (ndone == 0 && waitc < 5000) begin @(negedge clk); waitc++; end
        chk(ndone != 0, {tag, " R1 done seen"}, 32'(ndone), 32'd1);
        repeat (shang ? TMO + 30 : 6) @(negedge clk);
        build(op, chip, ra, alen, dlen, pres);
        ref_run(xres, xcmd, ok);
        chk(result === xres, {tag, " R2 R3 result"}, result, xres);
        chk(ndone == 1, {tag, " R10 single done"}, 32'(ndone), 32'd1);
        chk(nstop == 1, {tag, " R8 stop issued"}, 32'(nstop), 32'd1);
        chk(cmd_idx == xcmd, {tag, " R12 command count"}, 32'(cmd_idx), 32'(xcmd));
        chk(busy === 1'b0, {tag, " R10 idle after done"}, 32'(busy), 32'd0);
        if (ok) begin
            chk(nsent == nx, {tag, " R4 R7 R11 sent count"}, 32'(nsent), 32'(nx));
            for (int i = 0; i < nx && i < nsent; i++)
                chk(sent[i] == x_sent[i], {tag, " R4 R5 R7 sent byte"}, 32'(sent[i]), 32'(x_sent[i]));
            if (op != 0) begin
                chk(nrcv == ((op == 2) ? 1 : dlen), {tag, " R6 R9 rx count"}, 32'(nrcv), 32'((op == 2) ? 1 : dlen));
                for (int i = 0; i < nrcv; i++)
                    chk(rbuf[i] == 8'hA0 + 8'(i), {tag, " R6 rx byte"}, 32'(rbuf[i]), 32'(8'hA0 + 8'(i)));
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) wbuf[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R1 reset busy", 32'(busy), 32'd0);
        chk(done === 1'b0, "R1 reset done", 32'(done), 32'd0);
        chk(eng_cmd_valid === 1'b0, "R10 reset cmd", 32'(eng_cmd_valid), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_txn(0, 7'h50, 32'h11223344, 2, 3, 1'b1, 99, 1'b0, 1'b0, "R4 write");
        run_txn(1, 7'h2A, 32'hA1B2C3D4, 2, 3, 1'b1, 99, 1'b0, 1'b0, "R5 read");
        run_txn(1, 7'h2A, 32'h0000_0077, 1, 1, 1'b1, 99, 1'b0, 1'b0, "R6 read one");
        run_txn(2, 7'h3C, 32'h0, 0, 0, 1'b1, 99, 1'b0, 1'b0, "R9 probe hit");
        run_txn(2, 7'h3C, 32'h0, 0, 0, 1'b0, 99, 1'b0, 1'b0, "R9 probe miss");
        chk(result === 32'h01484840, "R9 probe nak word", result, 32'h01484840);
        run_txn(0, 7'h12, 32'h0000_00EE, 1, 0, 1'b1, 99, 1'b0, 1'b0, "R11 zero len");
        run_txn(0, 7'h12, 32'h0, 0, 0, 1'b1, 99, 1'b0, 1'b0, "R11 empty");
        run_txn(0, 7'h44, 32'hDEADBEEF, 5, 2, 1'b1, 99, 1'b0, 1'b0, "R7 clamp");
        run_txn(1, 7'h44, 32'hCAFEF00D, 4, 4, 1'b1, 99, 1'b0, 1'b0, "R7 four bytes");
        run_txn(0, 7'h21, 32'h00000102, 2, 3, 1'b1, 3, 1'b0, 1'b0, "R3 hang");
        run_txn(1, 7'h21, 32'h00000102, 2, 3, 1'b1, 0, 1'b0, 1'b0, "R3 hang start");
        run_txn(0, 7'h21, 32'h00000102, 1, 1, 1'b1, 99, 1'b1, 1'b0, "R8 stop timeout");
        run_txn(0, 7'h21, 32'h00000102, 1, 1, 1'b0, 99, 1'b1, 1'b0, "R8 first wins");
        run_txn(1, 7'h33, 32'h00005566, 2, 4, 1'b1, 99, 1'b0, 1'b1, "R10 inject");
        for (int t = 0; t < 40; t++) begin
            int op, al, dl, hg;
            logic pr, sh, inj;
            op  = $urandom_range(0, 2);
            al  = $urandom_range(0, 4);
            dl  = $urandom_range(0, 8);
            pr  = ($urandom_range(0, 9) < 8);
            hg  = ($urandom_range(0, 9) < 2) ? $urandom_range(0, 6) : 99;
            sh  = ($urandom_range(0, 9) == 0);
            inj = ($urandom_range(0, 4) == 0);
            run_txn(op, 7'($urandom), $urandom, al, dl, pr, hg, sh, inj, "R12 random");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule